// File: doc/BRIEF.md
# Matrix Multiply Coprocessor Controller

This block is the sequencing core of a matrix multiply coprocessor that sits beside a RISC-V core. The core sends it R-format custom instructions over a command/response handshake. Two instructions set the operand base addresses, the result base address and the dimension N. A third starts the run, and a fourth reads back the status. The controller then computes C = A × B on N×N matrices of 32-bit IEEE 754 words held in main memory. It issues every memory access itself, one at a time, so the core does no copying.

Storage is kept small. Only one row of A is held inside the block, and it is fetched once per output row. For each output column, the controller fetches the column of B element by element. Each B element is paired with the buffered A element and passed to an external floating-point multiply-accumulate unit through a valid/ready port. When the unit returns the dot product, the controller writes it to C. The arithmetic itself happens outside this block.

Each run ends with a done flag and a two-bit error code. The error code reports an unusable dimension, an output region that overlaps an input region, or an error response from memory.

Top module: `matmul_ctrl`

## Requirements
- R1: The command field `cmd_funct` selects the operation. Code 0 loads the A base from rs1 and the B base from rs2. Code 1 loads the C base from rs1 and N from rs2. Code 2 starts a run. Code 3 requests status. Any other code is accepted and changes nothing, and it produces no response.
- R2: A status command produces a response that carries the command's rd index. Its data word holds the done flag in bit 0, the error code in bits 2:1 and the busy flag in bit 3. The response stays valid and unchanged until `resp_ready` is high.
- R3: While a run is in progress, `cmd_ready` is low for every command except status. Status is accepted whenever no response is pending.
- R4: Matrices are row-major with 4-byte elements, so element (r,c) is at base + 4·(r·N + c). For each row i, the controller reads A(i,0..N-1) in order. Then, for each column j in order, it reads B(0..N-1,j) and after that writes C(i,j).
- R5: At most one memory request is outstanding. Each request keeps its address, direction and data until it is accepted.
- R6: The controller offers the multiply-accumulate pairs (A(i,k), B(k,j)) with k ascending. The last flag is set when k = N-1, and a pair stays stable while `mac_in_ready` is low. The value the unit returns is the data written to C(i,j).
- R7: Write requests only target addresses inside [C base, C base + 4·N·N), so the A and B regions are never modified.
- R8: A start with N = 0 or N > MAX_N ends the run with error code 1, done set, and no memory traffic.
- R9: A start whose output region overlaps the A or B region ends the run with error code 2 and no memory traffic. Regions that only touch at an edge do not count as overlapping.
- R10: An error response from memory ends the run with error code 3 and done set, and the controller issues no further requests.
- R11: A start clears done and the error code. Done is set when the run ends. The next run may use a different N and different bases, and a correctly configured run succeeds after a failed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered by the core |
| cmd_ready | output | 1 | Command accepted |
| cmd_funct | input | 7 | Operation code |
| cmd_rd | input | 5 | Destination register index for the response |
| cmd_rs1 | input | XW | First source operand |
| cmd_rs2 | input | XW | Second source operand |
| resp_valid | output | 1 | Status response pending |
| resp_ready | input | 1 | Core takes the response |
| resp_rd | output | 5 | Destination register index of the response |
| resp_data | output | XW | Status word |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | XW | Byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_resp_valid | input | 1 | Memory response (read data or write acknowledge) |
| mem_resp_rdata | input | 32 | Read data |
| mem_resp_err | input | 1 | Memory reports an error for this access |
| mac_in_valid | output | 1 | Operand pair offered |
| mac_in_ready | input | 1 | Unit accepts the pair |
| mac_in_a | output | 32 | Element of A |
| mac_in_b | output | 32 | Element of B |
| mac_in_last | output | 1 | Final pair of this dot product |
| mac_out_valid | input | 1 | Dot product available |
| mac_out_data | input | 32 | Dot product value |

## Verification
The bench builds the controller with MAX_N = 8 and a 32-bit address width. With MAX_N = 8, a full-size run of 8×8 takes only a few thousand cycles, and the upper dimension limit can be tested directly by starting with N = 9. Smaller runs of N = 1, 2, 3, 4 and 5 are also exercised. Memory and the multiply-accumulate unit withdraw ready on different fixed rhythms, so requests and operand pairs are often held while stalled. The unit is modelled with wrapping integer arithmetic, so every result word can be predicted exactly.

// File: rtl/matmul_ctrl.sv
module matmul_ctrl #(
  parameter int MAX_N = 32,
  parameter int XW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [6:0]    cmd_funct,
  input  logic [4:0]    cmd_rd,
  input  logic [XW-1:0] cmd_rs1,
  input  logic [XW-1:0] cmd_rs2,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [4:0]    resp_rd,
  output logic [XW-1:0] resp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [XW-1:0] mem_req_addr,
  output logic [31:0]   mem_req_wdata,
  input  logic          mem_resp_valid,
  input  logic [31:0]   mem_resp_rdata,
  input  logic          mem_resp_err,
  output logic          mac_in_valid,
  input  logic          mac_in_ready,
  output logic [31:0]   mac_in_a,
  output logic [31:0]   mac_in_b,
  output logic          mac_in_last,
  input  logic          mac_out_valid,
  input  logic [31:0]   mac_out_data
);
  localparam int CW = $clog2(MAX_N + 1);
  localparam int IW = $clog2(MAX_N);
  localparam logic [6:0] F_SET_AB = 7'd0, F_SET_CN = 7'd1, F_START = 7'd2, F_STATUS = 7'd3;
  localparam logic [1:0] E_NONE = 2'd0, E_DIM = 2'd1, E_OVL = 2'd2, E_MEM = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD_ROW, S_STREAM_COL, S_WAIT_MAC, S_STORE, S_NEXT, S_DONE
  } st_t;

  st_t            st;
  logic [XW-1:0]  a_base, b_base, c_base, n_cfg;
  logic [CW-1:0]  i_q, j_q, k_q;
  logic           wait_q, have_b, done_q;
  logic [1:0]     err_q;
  logic [31:0]    b_q, c_q;
  logic [31:0]    rowbuf [MAX_N];

  function automatic logic overlaps(input logic [XW-1:0] x, input logic [XW-1:0] y,
                                    input logic [XW-1:0] sz);
    return ({1'b0, x} < {1'b0, y} + {1'b0, sz}) && ({1'b0, y} < {1'b0, x} + {1'b0, sz});
  endfunction

  wire            busy     = (st != S_IDLE);
  wire            cmd_fire = cmd_valid && cmd_ready;
  wire [CW-1:0]   n_last   = n_cfg[CW-1:0] - 1'b1;
  wire [XW-1:0]   span     = (n_cfg * n_cfg) << 2;
  wire            bad_dim  = (n_cfg == '0) || (n_cfg > XW'(MAX_N));
  wire            ovl      = overlaps(c_base, a_base, span) || overlaps(c_base, b_base, span);
  wire [XW-1:0]   a_addr   = a_base + ((XW'(i_q) * n_cfg + XW'(k_q)) << 2);
  wire [XW-1:0]   b_addr   = b_base + ((XW'(k_q) * n_cfg + XW'(j_q)) << 2);
  wire [XW-1:0]   c_addr   = c_base + ((XW'(i_q) * n_cfg + XW'(j_q)) << 2);
  wire [XW-1:0]   status_w = {{(XW-4){1'b0}}, busy, err_q, done_q};

  assign cmd_ready     = !resp_valid && (!busy || cmd_funct == F_STATUS);
  assign mem_req_valid = !wait_q && (st == S_LOAD_ROW || st == S_STORE ||
                                     (st == S_STREAM_COL && !have_b));
  assign mem_req_we    = (st == S_STORE);
  assign mem_req_addr  = (st == S_LOAD_ROW) ? a_addr : (st == S_STORE) ? c_addr : b_addr;
  assign mem_req_wdata = c_q;
  assign mac_in_valid  = (st == S_STREAM_COL) && have_b;
  assign mac_in_a      = rowbuf[k_q[IW-1:0]];
  assign mac_in_b      = b_q;
  assign mac_in_last   = (k_q == n_last);

  always_ff @(posedge clk)
    if (st == S_LOAD_ROW && wait_q && mem_resp_valid && !mem_resp_err)
      rowbuf[k_q[IW-1:0]] <= mem_resp_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      a_base <= '0; b_base <= '0; c_base <= '0; n_cfg <= '0;
      i_q <= '0; j_q <= '0; k_q <= '0;
      wait_q <= 1'b0; have_b <= 1'b0; done_q <= 1'b0; err_q <= E_NONE;
      b_q <= '0; c_q <= '0;
      resp_valid <= 1'b0; resp_rd <= '0; resp_data <= '0;
    end else begin
      if (resp_valid && resp_ready) resp_valid <= 1'b0;
      if (cmd_fire) begin
        case (cmd_funct)
          F_SET_AB: begin a_base <= cmd_rs1; b_base <= cmd_rs2; end
          F_SET_CN: begin c_base <= cmd_rs1; n_cfg <= cmd_rs2; end
          F_START: begin
            done_q <= 1'b0; i_q <= '0; j_q <= '0; k_q <= '0;
            wait_q <= 1'b0; have_b <= 1'b0;
            if (bad_dim)  begin err_q <= E_DIM;  st <= S_DONE;     end
            else if (ovl) begin err_q <= E_OVL;  st <= S_DONE;     end
            else          begin err_q <= E_NONE; st <= S_LOAD_ROW; end
          end
          F_STATUS: begin resp_valid <= 1'b1; resp_rd <= cmd_rd; resp_data <= status_w; end
          default: ;
        endcase
      end
      if (mem_req_valid && mem_req_ready) wait_q <= 1'b1;
      if (wait_q && mem_resp_valid) begin
        wait_q <= 1'b0;
        if (mem_resp_err) begin
          err_q <= E_MEM;
          st    <= S_DONE;
        end else begin
          case (st)
            S_LOAD_ROW:
              if (k_q == n_last) begin k_q <= '0; st <= S_STREAM_COL; end
              else k_q <= k_q + 1'b1;
            S_STREAM_COL: begin b_q <= mem_resp_rdata; have_b <= 1'b1; end
            S_STORE: st <= S_NEXT;
            default: ;
          endcase
        end
      end
      if (mac_in_valid && mac_in_ready) begin
        have_b <= 1'b0;
        if (mac_in_last) begin k_q <= '0; st <= S_WAIT_MAC; end
        else k_q <= k_q + 1'b1;
      end
      if (st == S_WAIT_MAC && mac_out_valid) begin c_q <= mac_out_data; st <= S_STORE; end
      if (st == S_NEXT) begin
        if (j_q == n_last) begin
          j_q <= '0;
          if (i_q == n_last) st <= S_DONE;
          else begin i_q <= i_q + 1'b1; st <= S_LOAD_ROW; end
        end else begin
          j_q <= j_q + 1'b1;
          st  <= S_STREAM_COL;
        end
      end
      if (st == S_DONE) begin done_q <= 1'b1; st <= S_IDLE; end
    end
  end

  AST_WR_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we |-> mem_req_addr >= c_base && mem_req_addr < c_base + span); // R7
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)); // R5
  AST_MAC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    mac_in_valid && !mac_in_ready |=> mac_in_valid && $stable(mac_in_a) && $stable(mac_in_b) && $stable(mac_in_last)); // R6
  AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_data) && $stable(resp_rd)); // R2
  AST_BAD_DIM: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire && cmd_funct == F_START && bad_dim |=> err_q == E_DIM && !mem_req_valid); // R8
  AST_MEM_ERR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    wait_q && mem_resp_valid && mem_resp_err |=> !mem_req_valid && err_q == E_MEM); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !mac_in_valid); // R11
endmodule

// File: tb/sim_matmul_ctrl.sv
module sim_matmul_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXN = 8;
  localparam int WORDS = 4096;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [6:0] cmd_funct = '0;
  logic [4:0] cmd_rd = '0;
  logic [31:0] cmd_rs1 = '0, cmd_rs2 = '0;
  logic resp_valid, resp_ready = 1'b0;
  logic [4:0] resp_rd;
  logic [31:0] resp_data;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic mem_resp_valid = 1'b0, mem_resp_err = 1'b0;
  logic [31:0] mem_resp_rdata = '0;
  logic mac_in_valid, mac_in_ready = 1'b0, mac_in_last;
  logic [31:0] mac_in_a, mac_in_b;
  logic mac_out_valid = 1'b0;
  logic [31:0] mac_out_data = '0;

  matmul_ctrl #(.MAX_N(MAXN), .XW(32)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_funct(cmd_funct), .cmd_rd(cmd_rd),
    .cmd_rs1(cmd_rs1), .cmd_rs2(cmd_rs2),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rd(resp_rd), .resp_data(resp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_rdata(mem_resp_rdata), .mem_resp_err(mem_resp_err),
    .mac_in_valid(mac_in_valid), .mac_in_ready(mac_in_ready), .mac_in_a(mac_in_a),
    .mac_in_b(mac_in_b), .mac_in_last(mac_in_last),
    .mac_out_valid(mac_out_valid), .mac_out_data(mac_out_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, fires = 0;
  logic [31:0] mem  [WORDS];
  logic [31:0] snap [WORDS];
  logic [64:0] exp_req[$];
  logic [64:0] exp_mac[$];
  logic [64:0] e_req, e_mac;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  bit err_seen = 0;
  int m_n = 0;
  logic [31:0] m_a = 0, m_b = 0, m_c = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  bit m_pend = 0; logic m_we; logic [31:0] m_addr, m_wd;
  always @(negedge clk) begin
    mem_resp_valid = 1'b0; mem_resp_err = 1'b0;
    if (cmd_valid && cmd_ready && cmd_funct == 7'd2) err_seen = 0;
    if (m_pend) begin
      m_pend = 0; fires++;
      if (err_seen) chk(0, "R10", "request after error response", {1'b0, m_addr}, 0);
      else if (exp_req.size() == 0) chk(0, "R4", "unexpected request", {m_we, m_addr, m_wd}, 0);
      else begin
        e_req = exp_req.pop_front();
        chk(e_req[64] == m_we && e_req[63:32] == m_addr && (!m_we || e_req[31:0] == m_wd),
            m_we ? "R6" : "R4", "memory request", {m_we, m_addr, m_wd}, e_req);
      end
      if (m_we) chk(m_addr >= m_c && m_addr < m_c + 32'(4*m_n*m_n), "R7", "write address", {1'b0, m_addr}, {1'b0, m_c});
      mem_resp_valid = 1'b1;
      if (m_addr == err_addr) begin mem_resp_err = 1'b1; err_seen = 1; end
      else if (m_we) mem[m_addr[13:2]] = m_wd;
      else mem_resp_rdata = mem[m_addr[13:2]];
    end
    mem_req_ready = (cyc % 3) != 1;
    if (mem_req_valid && mem_req_ready) begin
      m_pend = 1; m_we = mem_req_we; m_addr = mem_req_addr; m_wd = mem_req_wdata;
    end
  end

  bit x_pend = 0; logic x_last; logic [31:0] x_a, x_b, acc = 0;
  always @(negedge clk) begin
    mac_out_valid = 1'b0;
    if (x_pend) begin
      x_pend = 0;
      if (exp_mac.size() == 0) chk(0, "R6", "unexpected MAC pair", {x_last, x_a, x_b}, 0);
      else begin
        e_mac = exp_mac.pop_front();
        chk(e_mac == {x_last, x_a, x_b}, "R6", "MAC pair", {x_last, x_a, x_b}, e_mac);
      end
      acc = acc + x_a * x_b;
      if (x_last) begin mac_out_valid = 1'b1; mac_out_data = acc; acc = 0; end
    end
    mac_in_ready = (cyc % 4) != 2;
    if (mac_in_valid && mac_in_ready) begin
      x_pend = 1; x_last = mac_in_last; x_a = mac_in_a; x_b = mac_in_b;
    end
  end

  function automatic logic [31:0] dot(input int i, input int j);
    logic [31:0] s = 0;
    for (int k = 0; k < m_n; k++)
      s = s + snap[m_a[13:2] + i*m_n + k] * snap[m_b[13:2] + k*m_n + j];
    return s;
  endfunction

  task automatic cmd(input logic [6:0] f, input logic [31:0] r1, input logic [31:0] r2,
                     input logic [4:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_funct = f; cmd_rs1 = r1; cmd_rs2 = r2; cmd_rd = rd;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic status(output logic [31:0] s);
    cmd(7'd3, 32'h0, 32'h0, 5'd7);
    chk(resp_valid && resp_rd == 5'd7, "R2", "status response and rd", {resp_valid, resp_rd}, {1'b1, 5'd7});
    s = resp_data;
    @(negedge clk);
    chk(resp_valid && resp_data == s, "R2", "response held while not ready", resp_data, s);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
  endtask

  task automatic configure(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, input int n);
    cmd(7'd0, a, b, 5'd0);
    cmd(7'd1, c, 32'(n), 5'd0);
    m_a = a; m_b = b; m_c = c; m_n = n;
  endtask

  task automatic fill(input int seed);
    for (int w = 0; w < WORDS; w++) mem[w] = 32'(w * 7 + seed * 13 + 1);
  endtask

  task automatic run(input int exp_err, input string tag, input bit probe);
    logic [31:0] s;
    int f0, bad;
    bit ok_run;
    ok_run = (exp_err == 0) && (m_n >= 1) && (m_n <= MAXN);
    for (int w = 0; w < WORDS; w++) snap[w] = mem[w];
    exp_req.delete(); exp_mac.delete();
    if (m_n >= 1 && m_n <= MAXN && exp_err != 1 && exp_err != 2)
      for (int i = 0; i < m_n; i++) begin
        for (int k = 0; k < m_n; k++) exp_req.push_back({1'b0, m_a + 32'(4*(i*m_n+k)), 32'h0});
        for (int j = 0; j < m_n; j++) begin
          for (int k = 0; k < m_n; k++) begin
            exp_req.push_back({1'b0, m_b + 32'(4*(k*m_n+j)), 32'h0});
            exp_mac.push_back({k == m_n-1, snap[m_a[13:2] + i*m_n + k], snap[m_b[13:2] + k*m_n + j]});
          end
          exp_req.push_back({1'b1, m_c + 32'(4*(i*m_n+j)), dot(i, j)});
        end
      end
    f0 = fires;
    cmd(7'd2, 32'h0, 32'h0, 5'd0);
    if (probe) begin
      @(negedge clk);
      cmd_valid = 1'b1; cmd_funct = 7'd0; cmd_rs1 = 32'h3000; cmd_rs2 = 32'h3400;
      for (int t = 0; t < 5; t++) begin
        #1; chk(cmd_ready == 1'b0, "R3", "config stalled while busy", cmd_ready, 0);
        @(negedge clk);
      end
      cmd_valid = 1'b0;
      status(s);
      chk(s[3] == 1'b1 && s[0] == 1'b0, "R11", "busy and done cleared after start", s[3:0], 4'b1000);
    end
    s = 0;
    for (int p = 0; p < 2000 && !s[0]; p++) begin
      repeat (40) @(negedge clk);
      status(s);
      if (!s[0]) chk(s[3] == 1'b1, "R3", "status accepted while busy", s[3:0], 4'b1000);
    end
    chk(s[0] == 1'b1 && s[3] == 1'b0, "R11", "done set at end", s[3:0], 4'b0001);
    chk(s[2:1] == 2'(exp_err), tag, "error code", s[2:1], 2'(exp_err));
    if (exp_err == 1 || exp_err == 2)
      chk(fires == f0, tag, "no memory traffic", fires - f0, 0);
    if (ok_run) begin
      chk(exp_req.size() == 0 && exp_mac.size() == 0, "R4", "all expected transfers seen",
          exp_req.size() + exp_mac.size(), 0);
      bad = 0;
      for (int w = 0; w < WORDS; w++) begin
        int off = w - int'(m_c[13:2]);
        if (off >= 0 && off < m_n*m_n) begin
          if (mem[w] != dot(off / m_n, off % m_n)) bad++;
        end else if (mem[w] != snap[w]) bad++;
      end
      chk(bad == 0, "R7", "result matrix correct and inputs preserved", bad, 0);
    end
    exp_req.delete(); exp_mac.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] s;
    fill(1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!mem_req_valid && !mac_in_valid && !resp_valid && cmd_ready, "R2", "reset state",
        {mem_req_valid, mac_in_valid, resp_valid, cmd_ready}, 4'b0001);
    status(s);
    chk(s[3:0] == 4'b0000, "R2", "initial status word", s[3:0], 0);

    configure(32'h000, 32'h400, 32'h800, 3);
    run(0, "R4", 1);

    fill(2);
    cmd(7'd9, 32'h404, 32'h9, 5'd3);
    repeat (3) begin
      @(negedge clk);
      chk(!resp_valid, "R1", "unknown code gives no response", resp_valid, 0);
    end
    run(0, "R1", 0);

    fill(3);
    configure(32'h100, 32'h600, 32'hA00, 5);
    run(0, "R11", 0);
    configure(32'h040, 32'h080, 32'h0C0, 1);
    run(0, "R4", 0);
    fill(4);
    configure(32'h000, 32'h400, 32'h800, 8);
    run(0, "R6", 0);

    configure(32'h000, 32'h400, 32'h800, 0);
    run(1, "R8", 0);
    configure(32'h000, 32'h400, 32'h800, 9);
    run(1, "R8", 0);

    configure(32'h000, 32'h400, 32'h008, 3);
    run(2, "R9", 0);
    configure(32'h000, 32'h400, 32'h3E0, 3);
    run(2, "R9", 0);
    fill(5);
    configure(32'h000, 32'h400, 32'h024, 3);
    run(0, "R9", 0);

    fill(6);
    configure(32'h000, 32'h400, 32'h800, 4);
    err_addr = 32'h010;
    run(3, "R10", 0);
    err_addr = 32'hFFFF_FFFF;
    repeat (5) @(negedge clk);

    fill(7);
    configure(32'h200, 32'h500, 32'h900, 2);
    run(0, "R11", 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule